// File: doc/BRIEF.md
# I2C Target Register Bridge

This block is an I2C target that gives an external host access to a small internal register file and to the write side of a transmit FIFO. SCL and SDA are sampled with a fast system clock, at least 16 times the SCL rate. The block recognises START, repeated START and STOP, and compares the first byte against a fixed 7-bit device address. In a write transfer, the byte that follows the address is a register pointer. Later data bytes are written at that pointer. A read transfer returns bytes starting at the pointer, usually after a repeated START.

One pointer value is reserved for the FIFO data port. Bytes written there leave through a valid/ready stream. Back-pressure rules: `fifo_valid` rises only for a byte the block has already acknowledged. It then stays high with `fifo_data` unchanged until a cycle in which `fifo_ready` is high. A byte is taken in exactly that cycle. If `fifo_ready` is low, or an earlier byte is still pending, at the moment the block must decide on the acknowledge, the byte is refused with a NACK and dropped.

SDA is open drain. `sda_oe` high pulls the line low. The block changes `sda_oe` only while SCL is low.

Top module: `i2c_reg_bridge`

## Requirements
- R1: A START (SDA falling while SCL is high) opens an address phase from any state, including in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the block to idle with `sda_oe` low.
- R2: The first byte after a START is the 7-bit address (MSB first) followed by a direction bit, where 1 means read. If the address equals `DEV_ADDR` (default 0x2A), the block pulls SDA low through the high phase of the ninth clock.
- R3: A non-matching address gets no acknowledge. The block then keeps SDA released, and writes no register, until the next START or STOP.
- R4: In a write transfer, the byte after the address is acknowledged and loaded into the register pointer.
- R5: Each later data byte whose pointer selects a stored register (1 to `NREGS`-1, default 1 to 7) is stored and acknowledged. The pointer then increments by one.
- R6: A data byte written while the pointer equals `FIFO_ADDR` (default 0x00) is acknowledged and offered once on `fifo_data` under the stream rules. The pointer does not move, so consecutive bytes all go to the FIFO in order.
- R7: If `fifo_ready` is low when a FIFO byte completes, the byte is answered with a NACK (SDA left high in the ninth clock) and is never offered on the stream.
- R8: After an address with the direction bit set to read, the block sends the byte at the pointer, MSB first. A host ACK advances the pointer (except at `FIFO_ADDR`) and sends the next byte. A host NACK ends the read with SDA released.
- R9: Pointers at or above `NREGS` read as 0x00 and take writes with an ACK but store nothing. `FIFO_ADDR` reads as 0x00.
- R10: `sda_oe` changes only while SCL is low.
- R11: After reset, `sda_oe` and `fifo_valid` are low and every stored register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| fifo_valid | output | 1 | A byte for the transmit FIFO is offered |
| fifo_ready | input | 1 | The FIFO can take a byte (not full) |
| fifo_data | output | 8 | Byte offered to the FIFO |

## Verification
A wrong bit counter or state shows up within a single byte. The acknowledge in the ninth clock comes out inverted or shifted, and the next byte is received as garbage. A wrong pointer shows up only on the next read-back, when a register returns a neighbour's value or stays 0x00. A broken FIFO path shows up on the stream: a byte is missing, doubled, or appears after a NACK, and the scoreboard sees this within a few cycles of the ninth clock.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_SUB,
    ST_ACK_S,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_RACK,
    ST_SKIP
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] scl_chain, sda_chain;
  logic scl_now, scl_prev, sda_prev;

  // Synchronizer plus one history stage, reset to the idle-high line level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
    end else begin
      scl_chain <= {scl_chain[CHAIN-2:0], scl_i};
      sda_chain <= {sda_chain[CHAIN-2:0], sda_i};
    end
  end

  assign scl_now  = scl_chain[SYNC_STAGES-1];
  assign scl_prev = scl_chain[SYNC_STAGES];
  assign sda_s    = sda_chain[SYNC_STAGES-1];
  assign sda_prev = sda_chain[SYNC_STAGES];

  assign scl_rise = scl_now & ~scl_prev;
  assign scl_fall = ~scl_now & scl_prev;
  assign start_p  = scl_now & scl_prev & sda_prev & ~sda_s;
  assign stop_p   = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter int NREGS     = 8,
  parameter int FIFO_ADDR = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] waddr,
  input  logic [7:0] wdata,
  input  logic [7:0] raddr,
  output logic [7:0] rdata
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [NREGS-1:0][7:0] regs;
  logic                  rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (we) begin
      for (int i = 0; i < NREGS; i++) begin
        if (i != FIFO_ADDR && waddr == 8'(i)) regs[i] <= wdata;
      end
    end
  end

  assign rd_hit = (32'(raddr) < NREGS) && (raddr != 8'(FIFO_ADDR));
  assign rdata  = rd_hit ? regs[raddr[IW-1:0]] : 8'h00;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_bridge_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h2A,
  parameter int         FIFO_ADDR = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_p,
  input  logic       stop_p,
  output logic       sda_oe,
  output logic       reg_we,
  output logic [7:0] reg_waddr,
  output logic [7:0] reg_wdata,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       fifo_valid,
  input  logic       fifo_ready,
  output logic [7:0] fifo_data
);
  tgt_state_e  state;
  logic [3:0]  cnt;
  logic [7:0]  sh, txsh, ptr;
  logic        rw, mack, ptr_is_fifo;

  assign ptr_is_fifo = (ptr == 8'(FIFO_ADDR));
  // During the host ACK slot, look ahead to the next read byte.
  assign rd_addr = (state == ST_RACK && !ptr_is_fifo) ? ptr + 8'd1 : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sh <= '0; txsh <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      reg_we <= 1'b0; reg_waddr <= '0; reg_wdata <= '0;
      fifo_valid <= 1'b0; fifo_data <= '0;
    end else begin
      reg_we <= 1'b0;
      if (fifo_valid && fifo_ready) fifo_valid <= 1'b0;
      if (start_p) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_p) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        if (scl_rise) begin
          case (state)
            ST_ADDR, ST_SUB, ST_WR: begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end
            ST_RD:   cnt  <= cnt + 4'd1;
            ST_RACK: mack <= ~sda_s;
            default: ;
          endcase
        end
        if (scl_fall) begin
          case (state)
            ST_ADDR: if (cnt == 4'd8) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1; rw <= sh[0]; state <= ST_ACK_A;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_ACK_A: begin
              cnt <= '0;
              if (rw) begin
                txsh <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_RD;
              end else begin
                sda_oe <= 1'b0; state <= ST_SUB;
              end
            end
            ST_SUB: if (cnt == 4'd8) begin
              ptr <= sh; sda_oe <= 1'b1; state <= ST_ACK_S;
            end
            ST_ACK_S, ST_ACK_W: begin
              sda_oe <= 1'b0; cnt <= '0; state <= ST_WR;
            end
            ST_WR: if (cnt == 4'd8) begin
              state <= ST_ACK_W;
              if (ptr_is_fifo) begin
                if (fifo_ready && !fifo_valid) begin
                  fifo_valid <= 1'b1; fifo_data <= sh; sda_oe <= 1'b1;
                end else begin
                  sda_oe <= 1'b0;
                end
              end else begin
                reg_we <= 1'b1; reg_waddr <= ptr; reg_wdata <= sh;
                ptr <= ptr + 8'd1; sda_oe <= 1'b1;
              end
            end
            ST_RD: if (cnt == 4'd8) begin
              sda_oe <= 1'b0; state <= ST_RACK;
            end else begin
              txsh <= {txsh[6:0], 1'b0}; sda_oe <= ~txsh[6];
            end
            ST_RACK: begin
              cnt <= '0;
              if (mack) begin
                ptr <= rd_addr; txsh <= rd_data; sda_oe <= ~rd_data[7];
                state <= ST_RD;
              end else begin
                sda_oe <= 1'b0; state <= ST_SKIP;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NREGS       = 8,
  parameter int         FIFO_ADDR   = 0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       fifo_valid,
  input  logic       fifo_ready,
  output logic [7:0] fifo_data
);
  logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic       reg_we;
  logic [7:0] reg_waddr, reg_wdata, rd_addr, rd_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .FIFO_ADDR(FIFO_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data)
  );

  i2c_reg_file #(.NREGS(NREGS), .FIFO_ADDR(FIFO_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
    .wdata(reg_wdata), .raddr(rd_addr), .rdata(rd_data)
  );

endmodule

// File: rtl/i2c_reg_bridge_chk.sv
module i2c_reg_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       fifo_valid,
  input logic       fifo_ready,
  input logic [7:0] fifo_data,
  input logic       stop_p
);
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  p_push_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && !fifo_ready) |=> (fifo_valid && $stable(fifo_data)));

  p_push_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && fifo_ready) |=> !fifo_valid);

  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_oe);

endmodule

bind i2c_reg_bridge i2c_reg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
  .fifo_data(fifo_data), .stop_p(stop_p)
);

// File: tb/i2c_reg_bridge_bench.sv
`timescale 1ns/1ps
module i2c_reg_bridge_bench;
  localparam int H = 40;
  localparam int Q = 20;
  localparam logic [7:0] AW = 8'h54;
  localparam logic [7:0] AR = 8'h55;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, fifo_ready = 1'b1;
  logic sda_oe, fifo_valid;
  logic [7:0] fifo_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, oe_viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  i2c_reg_bridge u_i2c_reg_bridge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .fifo_data(fifo_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor for the FIFO stream and the SDA timing rule.
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_valid && fifo_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R7 actual=%h expected=none (unexpected push)", fifo_data);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (fifo_data !== e) begin
            fails++;
            $display("FAIL R6 actual=%h expected=%h", fifo_data, e);
          end
        end
      end
      if (sda_oe != prev_oe && scl_m) oe_viol++;
    end
    prev_oe = sda_oe;
  end

  task automatic i2c_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H/2); ack = ~sda_line; wt(H/2);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic rb(input logic host_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl_m = 1'b1; wt(H/2); b = {b[6:0], sda_line}; wt(H/2); scl_m = 1'b0;
    end
    wt(Q); sda_m = ~host_ack; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q); sda_m = 1'b1;
  endtask

  task automatic read1(input logic [7:0] sub, output logic [7:0] d);
    logic a;
    i2c_start(); wb(AW, a); wb(sub, a); i2c_start(); wb(AR, a); rb(1'b0, d); i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    wt(10);
    chk("R11 sda_oe in reset", {7'd0, sda_oe}, 8'h00);
    chk("R11 fifo_valid in reset", {7'd0, fifo_valid}, 8'h00);
    rst_n = 1'b1; wt(10);
    read1(8'h05, d); chk("R11 reg5 after reset", d, 8'h00);

    // Register write with auto-increment.
    i2c_start(); wb(AW, a); chk("R2 address ack", {7'd0, a}, 8'h01);
    wb(8'h03, a); chk("R4 sub-address ack", {7'd0, a}, 8'h01);
    wb(8'h5A, a); chk("R5 data ack", {7'd0, a}, 8'h01);
    wb(8'hC3, a); chk("R5 second data ack", {7'd0, a}, 8'h01);
    i2c_stop(); wt(5);
    chk("R1 released after stop", {7'd0, sda_oe}, 8'h00);

    // Read back across a repeated START.
    i2c_start(); wb(AW, a); wb(8'h03, a); i2c_start();
    wb(AR, a); chk("R8 read address ack", {7'd0, a}, 8'h01);
    rb(1'b1, d); chk("R8 first read byte", d, 8'h5A);
    rb(1'b0, d); chk("R5 incremented pointer read", d, 8'hC3);
    wt(5); chk("R8 released after host nack", {7'd0, sda_oe}, 8'h00);
    i2c_stop();

    // Wrong device address.
    i2c_start(); wb(8'h22, a); chk("R3 mismatch no ack", {7'd0, a}, 8'h00);
    wb(8'h03, a); chk("R3 later byte no ack", {7'd0, a}, 8'h00);
    wb(8'hFF, a); chk("R3 data no ack", {7'd0, a}, 8'h00);
    i2c_stop();
    read1(8'h03, d); chk("R3 register untouched", d, 8'h5A);

    // FIFO writes, pointer stays.
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    i2c_start(); wb(AW, a); wb(8'h00, a);
    wb(8'h11, a); chk("R6 fifo byte ack", {7'd0, a}, 8'h01);
    wb(8'h22, a); chk("R6 second fifo byte ack", {7'd0, a}, 8'h01);
    i2c_stop(); wt(20);
    chk("R6 all fifo bytes seen", 8'(exp_q.size()), 8'h00);

    // Full FIFO refusal.
    fifo_ready = 1'b0;
    i2c_start(); wb(AW, a); wb(8'h00, a);
    wb(8'h33, a); chk("R7 nack when full", {7'd0, a}, 8'h00);
    i2c_stop(); wt(10);
    fifo_ready = 1'b1; wt(50);
    chk("R7 no stream activity", {7'd0, fifo_valid}, 8'h00);

    // Out-of-range and FIFO-address reads.
    i2c_start(); wb(AW, a); wb(8'h20, a);
    wb(8'h77, a); chk("R9 out-of-range write ack", {7'd0, a}, 8'h01);
    i2c_stop();
    read1(8'h20, d); chk("R9 out-of-range reads zero", d, 8'h00);
    read1(8'h00, d); chk("R9 fifo address reads zero", d, 8'h00);

    // Multi-byte write then three-byte burst read.
    i2c_start(); wb(AW, a); wb(8'h01, a); wb(8'hA1, a); wb(8'hB2, a); i2c_stop();
    i2c_start(); wb(AW, a); wb(8'h01, a); i2c_start(); wb(AR, a);
    rb(1'b1, d); chk("R8 burst byte 1", d, 8'hA1);
    rb(1'b1, d); chk("R8 burst byte 2", d, 8'hB2);
    rb(1'b0, d); chk("R5 burst byte 3", d, 8'h5A);
    i2c_stop(); wt(20);

    chk("R10 sda changes only with scl low", 8'(oe_viol), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule